// File: doc/BRIEF.md
# Convolver Sum and Precision Post-Processor

This block is the back end of a convolution processing engine. Each cycle it can accept one signed result from each of several parallel convolvers. It sums them in a registered adder tree and adds an addend. The addend is either a per-layer bias or zero; zero is used when partial sums are fed back for another accumulation pass.

Fixed-point data keep a 16-bit width, but the position of the radix point changes from layer to layer. The bias is moved left by a bias shift to line up with the accumulator's radix point. The sum is then moved right by a data shift to match the next layer's format, and is clamped to 16 bits.

Two optional stages follow: a rectifier and a 2x2, stride-2 max pool over a row-major stream. Each stage has its own bypass bit that travels with the beat. The convolvers, buffers and instruction decoder lie outside this block.

Top module: `pe_postproc`

## Requirements
- R1: The value summed for a beat is the signed total of all N_CONV lanes of `in_data`. Lane i sits at bits [i*IN_W +: IN_W] and is a two's complement number.
- R2: When `zero_sel` is 0, the addend is the signed `bias` shifted left by `bias_shift` bit positions.
- R3: When `zero_sel` is 1, the addend is zero, and `bias` and `bias_shift` have no effect on the result.
- R4: The accumulated value is arithmetically shifted right by `data_shift`, which rounds toward minus infinity.
- R5: The shifted value is clamped to the range -32768 to 32767 instead of wrapping.
- R6: When `relu_bypass` is 0, negative results become 0. When it is 1, the sign is kept.
- R7: When `pool_bypass` is 1, every accepted beat produces one output, in order. `out_valid` rises exactly 4 clock edges after the edge that samples the beat.
- R8: When `pool_bypass` is 0, pooled beats fill a row-major grid that is ROW_LEN values wide. A result appears only for the beat that closes a 2x2 window: odd row and odd column, counted from 0. The result is the largest of the window's four values and appears 4 edges after that beat.
- R9: Reset clears `out_valid` and returns the pooling position to row 0, column 0. A partial frame left before reset has no effect on later windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A beat is presented this cycle |
| in_data | input | N_CONV*IN_W (96) | Packed signed convolver results, lane 0 at the low bits |
| bias | input | 16 | Signed bias for this beat |
| bias_shift | input | SHIFT_W (4) | Left shift applied to the bias |
| data_shift | input | SHIFT_W (4) | Arithmetic right shift applied to the sum |
| zero_sel | input | 1 | 1 selects a zero addend instead of the bias |
| relu_bypass | input | 1 | 1 skips the rectifier |
| pool_bypass | input | 1 | 1 skips max pooling |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | 16 | Signed 16-bit result |

## Verification
The hardest case to reach from the ports is a reset that arrives while the pool line buffer holds maxima from the top row of a frame. Those stale values could leak into the next frame's windows.

The stimulus streams one full pooled row, pulses reset, and then streams two new rows. The new rows are chosen so that every new window maximum is smaller than the matching stale entry. Any leak therefore shows up as a wrong value or as an extra output.

Separate sequences cover clamping at both ends, rounding of negative values in the right shift, and a row of all-negative windows with the rectifier bypassed.

// File: rtl/pp_pkg.sv
package pp_pkg;

   // Flags that ride with a beat past the precision stage.
   typedef struct packed {
      logic relu_bypass;
      logic pool_bypass;
   } pp_post_t;

   // Accumulator width wide enough for the tree sum and the largest shifted bias.
   function automatic int acc_width(input int in_w, input int lanes,
                                    input int bias_w, input int shift_w);
      int lvl;
      int tree_w;
      int bias_sh_w;
      lvl = (lanes > 1) ? $clog2(lanes) : 0;
      tree_w = in_w + lvl;
      bias_sh_w = bias_w + (1 << shift_w) - 1;
      return ((tree_w > bias_sh_w) ? tree_w : bias_sh_w) + 1;
   endfunction

endpackage

// File: rtl/pp_adder_tree.sv
module pp_adder_tree #(
   parameter int LANES = 4,
   parameter int IN_W  = 24,
   parameter int SUM_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [LANES*IN_W-1:0]    in_data,
   output logic                     sum_valid,
   output logic signed [SUM_W-1:0]  sum
);
   localparam int LVL = (LANES > 1) ? $clog2(LANES) : 0;
   localparam int NP  = 1 << LVL;

   if (SUM_W < IN_W + LVL) begin : g_chk_w
      $error("pp_adder_tree: SUM_W too narrow");
   end

   for (genvar l = 0; l <= LVL; l++) begin : g_lvl
      logic signed [SUM_W-1:0] v [NP >> l];
      for (genvar k = 0; k < (NP >> l); k++) begin : g_node
         if (l == 0) begin : g_leaf
            if (k < LANES) begin : g_real
               logic [IN_W-1:0] lane;
               assign lane = in_data[k*IN_W +: IN_W];
               assign v[k] = {{(SUM_W-IN_W){lane[IN_W-1]}}, lane};
            end else begin : g_pad
               assign v[k] = '0;
            end
         end else begin : g_add
            assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_valid <= 1'b0;
         sum       <= '0;
      end else begin
         sum_valid <= in_valid;
         if (in_valid) sum <= g_lvl[LVL].v[0];
      end
   end

   assert_tree_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> sum_valid);

endmodule

// File: rtl/pp_align.sv
module pp_align #(
   parameter int ACC_W   = 32,
   parameter int BIAS_W  = 16,
   parameter int SHIFT_W = 4,
   parameter int OUT_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     v_in,
   input  logic signed [ACC_W-1:0]  sum,
   input  logic [BIAS_W-1:0]        bias,
   input  logic [SHIFT_W-1:0]       bias_shift,
   input  logic [SHIFT_W-1:0]       data_shift,
   input  logic                     zero_sel,
   input  pp_pkg::pp_post_t         post_in,
   output logic                     v_q,
   output logic signed [OUT_W-1:0]  data_q,
   output pp_pkg::pp_post_t         post_q
);
   if (ACC_W < BIAS_W + (1 << SHIFT_W) || ACC_W <= OUT_W) begin : g_chk_w
      $error("pp_align: ACC_W too narrow");
   end

   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] bias_ext, addend, acc, shifted;
   logic signed [OUT_W-1:0] clamped;

   always_comb begin
      bias_ext = {{(ACC_W-BIAS_W){bias[BIAS_W-1]}}, bias};
      addend   = zero_sel ? '0 : (bias_ext <<< bias_shift);
      acc      = sum + addend;
      shifted  = acc >>> data_shift;
      if (shifted > MAXV)      clamped = {1'b0, {(OUT_W-1){1'b1}}};
      else if (shifted < MINV) clamped = {1'b1, {(OUT_W-1){1'b0}}};
      else                     clamped = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         data_q <= '0;
         post_q <= '0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            data_q <= clamped;
            post_q <= post_in;
         end
      end
   end

   assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && zero_sel && data_shift == '0 && sum <= MAXV && sum >= MINV)
      |=> (data_q == $past(sum[OUT_W-1:0])));

endmodule

// File: rtl/pp_relu.sv
module pp_relu #(
   parameter int W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_in,
   input  logic signed [W-1:0]  din,
   input  pp_pkg::pp_post_t     post_in,
   output logic                 v_q,
   output logic signed [W-1:0]  data_q,
   output logic                 pool_bypass_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q           <= 1'b0;
         data_q        <= '0;
         pool_bypass_q <= 1'b0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            data_q        <= (!post_in.relu_bypass && din[W-1]) ? '0 : din;
            pool_bypass_q <= post_in.pool_bypass;
         end
      end
   end

   assert_relu_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && !post_in.relu_bypass) |=> !data_q[W-1]);
   assert_relu_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && post_in.relu_bypass) |=> (data_q == $past(din)));

endmodule

// File: rtl/pp_maxpool.sv
module pp_maxpool #(
   parameter int W       = 16,
   parameter int ROW_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_in,
   input  logic signed [W-1:0]  din,
   input  logic                 bypass,
   output logic                 out_valid,
   output logic signed [W-1:0]  out_data
);
   localparam int COL_W = $clog2(ROW_LEN);
   localparam int HALF  = ROW_LEN / 2;

   if (ROW_LEN < 4 || (ROW_LEN % 2) != 0) begin : g_chk_row
      $error("pp_maxpool: ROW_LEN must be even and at least 4");
   end

   logic [COL_W-1:0]    col;
   logic                odd_row;
   logic signed [W-1:0] hold;
   logic signed [W-1:0] line [HALF];
   logic signed [W-1:0] pair_max, quad_max, upper;
   logic                last_col;

   always_comb begin
      upper    = line[col[COL_W-1:1]];
      pair_max = (hold > din) ? hold : din;
      quad_max = (pair_max > upper) ? pair_max : upper;
      last_col = (col == COL_W'(ROW_LEN - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col       <= '0;
         odd_row   <= 1'b0;
         hold      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         for (int i = 0; i < HALF; i++) line[i] <= '0;
      end else begin
         out_valid <= 1'b0;
         if (v_in && bypass) begin
            out_valid <= 1'b1;
            out_data  <= din;
         end else if (v_in) begin
            if (!col[0]) begin
               hold <= din;
            end else if (!odd_row) begin
               line[col[COL_W-1:1]] <= pair_max;
            end else begin
               out_valid <= 1'b1;
               out_data  <= quad_max;
            end
            if (last_col) begin
               col     <= '0;
               odd_row <= !odd_row;
            end else begin
               col <= col + 1'b1;
            end
         end
      end
   end

   assert_out_has_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(v_in));
   assert_pool_ge_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && !bypass && odd_row && col[0]) |=> (out_valid && out_data >= $past(din)));
   assert_pool_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && !bypass && !(odd_row && col[0])) |=> !out_valid);

endmodule

// File: rtl/pe_postproc.sv
module pe_postproc #(
   parameter int N_CONV  = 4,
   parameter int IN_W    = 24,
   parameter int BIAS_W  = 16,
   parameter int SHIFT_W = 4,
   parameter int OUT_W   = 16,
   parameter int ROW_LEN = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [N_CONV*IN_W-1:0]   in_data,
   input  logic [BIAS_W-1:0]        bias,
   input  logic [SHIFT_W-1:0]       bias_shift,
   input  logic [SHIFT_W-1:0]       data_shift,
   input  logic                     zero_sel,
   input  logic                     relu_bypass,
   input  logic                     pool_bypass,
   output logic                     out_valid,
   output logic [OUT_W-1:0]         out_data
);
   import pp_pkg::*;

   localparam int ACC_W = acc_width(IN_W, N_CONV, BIAS_W, SHIFT_W);

   if (N_CONV < 1 || IN_W < 2 || OUT_W < 2) begin : g_chk_p
      $error("pe_postproc: bad lane parameters");
   end

   // Stage 1: tree sum, with per-beat controls registered alongside.
   logic                    s1_v;
   logic signed [ACC_W-1:0] s1_sum;
   logic [BIAS_W-1:0]       s1_bias;
   logic [SHIFT_W-1:0]      s1_bsh, s1_dsh;
   logic                    s1_zero;
   pp_post_t                s1_post;

   pp_adder_tree #(.LANES(N_CONV), .IN_W(IN_W), .SUM_W(ACC_W)) tree_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .sum_valid(s1_v), .sum(s1_sum));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_bias <= '0;
         s1_bsh  <= '0;
         s1_dsh  <= '0;
         s1_zero <= 1'b0;
         s1_post <= '0;
      end else if (in_valid) begin
         s1_bias <= bias;
         s1_bsh  <= bias_shift;
         s1_dsh  <= data_shift;
         s1_zero <= zero_sel;
         s1_post <= '{relu_bypass: relu_bypass, pool_bypass: pool_bypass};
      end
   end

   // Stage 2: addend, realignment, clamp.
   logic                    s2_v;
   logic signed [OUT_W-1:0] s2_data;
   pp_post_t                s2_post;

   pp_align #(.ACC_W(ACC_W), .BIAS_W(BIAS_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) align_i (
      .clk(clk), .rst_n(rst_n), .v_in(s1_v), .sum(s1_sum), .bias(s1_bias),
      .bias_shift(s1_bsh), .data_shift(s1_dsh), .zero_sel(s1_zero),
      .post_in(s1_post), .v_q(s2_v), .data_q(s2_data), .post_q(s2_post));

   // Stage 3: rectifier.
   logic                    s3_v;
   logic signed [OUT_W-1:0] s3_data;
   logic                    s3_pool_byp;

   pp_relu #(.W(OUT_W)) relu_i (
      .clk(clk), .rst_n(rst_n), .v_in(s2_v), .din(s2_data), .post_in(s2_post),
      .v_q(s3_v), .data_q(s3_data), .pool_bypass_q(s3_pool_byp));

   // Stage 4: pooling or pass-through.
   logic signed [OUT_W-1:0] s4_data;

   pp_maxpool #(.W(OUT_W), .ROW_LEN(ROW_LEN)) pool_i (
      .clk(clk), .rst_n(rst_n), .v_in(s3_v), .din(s3_data), .bypass(s3_pool_byp),
      .out_valid(out_valid), .out_data(s4_data));

   assign out_data = s4_data;

   assert_bypass_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pool_bypass) |-> ##4 out_valid);

endmodule

// File: tb/pe_postproc_tb_top.sv
`timescale 1ns/1ps
module pe_postproc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [95:0] in_data = '0;
   logic [15:0] bias = '0;
   logic [3:0]  bias_shift = '0;
   logic [3:0]  data_shift = '0;
   logic        zero_sel = 1'b0;
   logic        relu_bypass = 1'b0;
   logic        pool_bypass = 1'b1;
   logic        out_valid;
   logic [15:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int act_q[$];
   int exp_q[$];

   always #4 clk = ~clk;

   pe_postproc dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .bias(bias), .bias_shift(bias_shift), .data_shift(data_shift),
      .zero_sel(zero_sel), .relu_bypass(relu_bypass), .pool_bypass(pool_bypass),
      .out_valid(out_valid), .out_data(out_data));

   always @(negedge clk) if (rst_n && out_valid) act_q.push_back(int'($signed(out_data)));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input longint s, input int b, input int bsh, input int dsh,
                                input bit z, input bit rb);
      longint a;
      a = s + (z ? 64'sd0 : (longint'(b) <<< bsh));
      a = a >>> dsh;
      if (a > 32767) a = 32767;
      if (a < -32768) a = -32768;
      if (!rb && a < 0) a = 0;
      return int'(a);
   endfunction

   task automatic beat(input int l0, input int l1, input int l2, input int l3,
                       input int b, input int bsh, input int dsh,
                       input bit z, input bit rb, input bit pb);
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = {l3[23:0], l2[23:0], l1[23:0], l0[23:0]};
      bias        = b[15:0];
      bias_shift  = bsh[3:0];
      data_shift  = dsh[3:0];
      zero_sel    = z;
      relu_bypass = rb;
      pool_bypass = pb;
      if (pb) exp_q.push_back(model(longint'(l0) + l1 + l2 + l3, b, bsh, dsh, z, rb));
   endtask

   task automatic drain(input string req);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk(act_q.size() == exp_q.size(), {req, " count"}, act_q.size(), exp_q.size());
      foreach (exp_q[i])
         if (i < act_q.size()) chk(act_q[i] == exp_q[i], req, act_q[i], exp_q[i]);
      act_q.delete();
      exp_q.delete();
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
   endtask

   task automatic t_latency();
      int hit;
      hit = 0;
      beat(1, 2, 3, 4, 5, 2, 0, 1'b0, 1'b1, 1'b1);     // R1 R2: 10 + (5<<2) = 30
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         if (i == 1) in_valid = 1'b0;
         if (out_valid && hit == 0) hit = i;
      end
      chk(hit == 4, "R7 latency", hit, 4);
      drain("R1 R2 sum plus bias");
   endtask

   task automatic t_zero();
      beat(100, -30, 7, 1, 1234, 3, 0, 1'b1, 1'b1, 1'b1);   // R3 bias ignored
      beat(100, -30, 7, 1, -999, 7, 0, 1'b1, 1'b1, 1'b1);
      beat(-50, 0, 0, 0, 20, 1, 0, 1'b0, 1'b1, 1'b1);       // R2 bias used
      drain("R3 zero addend");
   endtask

   task automatic t_shift();
      beat(-7, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, 1'b1);   // R4 -4
      beat(7, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, 1'b1);    // R4 3
      beat(1000, 0, 0, 0, 0, 0, 3, 1'b1, 1'b1, 1'b1); // R4 125
      beat(2, 0, 0, 0, 3, 4, 2, 1'b0, 1'b1, 1'b1);    // R4 R2 (2+48)>>2 = 12
      beat(-1, 0, 0, 0, 0, 0, 15, 1'b1, 1'b1, 1'b1);  // R4 -1
      drain("R4 right shift");
   endtask

   task automatic t_sat();
      beat(8388607, 8388607, 8388607, 8388607, 0, 0, 0, 1'b1, 1'b1, 1'b1);
      beat(-8388608, -8388608, -8388608, -8388608, 0, 0, 0, 1'b1, 1'b1, 1'b1);
      beat(0, 0, 0, 0, -32768, 15, 15, 1'b0, 1'b1, 1'b1);
      beat(32767, 1, 0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
      beat(0, 0, 0, 0, 32767, 15, 0, 1'b0, 1'b1, 1'b1);
      drain("R5 clamp");
   endtask

   task automatic t_relu();
      beat(-500, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b1);  // R6 -> 0
      beat(-500, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b1);  // R6 kept
      beat(321, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b1);
      drain("R6 rectifier");
   endtask

   task automatic pool_frame(input int r0[8], input int r1[8], input bit rb);
      for (int c = 0; c < 8; c++) beat(r0[c], 0, 0, 0, 0, 0, 0, 1'b1, rb, 1'b0);
      for (int c = 0; c < 8; c++) beat(r1[c], 0, 0, 0, 0, 0, 0, 1'b1, rb, 1'b0);
      for (int w = 0; w < 4; w++) begin
         int m;
         m = r0[2*w];
         if (r0[2*w+1] > m) m = r0[2*w+1];
         if (r1[2*w] > m) m = r1[2*w];
         if (r1[2*w+1] > m) m = r1[2*w+1];
         if (!rb && m < 0) m = 0;
         exp_q.push_back(m);
      end
   endtask

   task automatic t_pool();
      int a0[8] = '{3, -1, 7, 2, 0, 5, -4, -6};
      int a1[8] = '{1, 9, -2, 4, 6, 5, -8, -5};
      int n0[8] = '{-9, -3, -7, -20, -1, -2, -30, -31};
      int n1[8] = '{-4, -8, -6, -5, -3, -9, -40, -32};
      pool_frame(a0, a1, 1'b1);
      pool_frame(n0, n1, 1'b1);
      pool_frame(n0, n1, 1'b0);
      drain("R8 max pool");
   endtask

   task automatic t_reset_mid_pool();
      int big[8] = '{900, 900, 900, 900, 900, 900, 900, 900};
      int b0[8]  = '{1, 2, 3, 4, 5, 6, 7, 8};
      int b1[8]  = '{8, 7, 6, 5, 4, 3, 2, 1};
      for (int c = 0; c < 8; c++) beat(big[c], 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      pool_frame(b0, b1, 1'b1);
      drain("R9 pool restart");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_zero();
      t_shift();
      t_sat();
      t_relu();
      t_pool();
      t_reset_mid_pool();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule